// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block merges five reset requests into a single system reset and remembers which source caused the most recent one. The sources are an active-low external reset pin, a supply-monitor trip, a missing-clock detector, a comparator trip and a watchdog expiry. Each asynchronous request passes through a two-flop synchronizer. A fixed priority then picks the cause. The reset output stays asserted while any request is active. After the requests clear, it stays asserted for a post-reset delay, counted in reference ticks. A reset caused by the supply monitor skips this delay.

Software sees one 8-bit register. Some of its bits are both enable controls and cause flags. A write sets the enables. A read returns the cause flags, which are updated at the moment the reset releases. The missing-clock detector runs from an always-running controller clock. It samples the monitored system clock as data and measures stuck time in reference ticks. A clock stuck high and a clock stuck low are detected alike. Enabling the supply monitor by a write forces an immediate reset. Writing 1 to that bit while the monitor is already on does nothing.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While the external pin is low, `sys_rst_o` stays high. After the pin rises and the reset releases, the register reads 8'h01 (bit 0).
- R2: Each reset leaves exactly one cause flag set, the one for its recorded cause. All earlier flags are cleared. Flags do not change while out of reset.
- R3: With bit 2 enabled, a monitored clock held at one level for MCD_TICKS reference ticks causes a reset, and the register then reads 8'h04. A shorter stall causes no reset.
- R4: With bit 2 written 0, a stalled monitored clock causes no reset. Every reset clears the bit-2 enable.
- R5: With bit 5 written 1, a low comparator output holds the reset, and the register then reads 8'h20. With bit 5 at 0, the comparator has no effect. Every reset clears the bit-5 enable.
- R6: A one-cycle watchdog expiry pulse causes a reset, and the register then reads 8'h08 (bit 3).
- R7: Writing bit 1 as 1 while the supply monitor is off enables it and forces a reset that reads 8'h02. The monitor stays enabled after that reset.
- R8: Writing bit 1 as 1 while the supply monitor is already on causes no reset.
- R9: A supply-cause reset releases within a few cycles after its request clears. Every other cause holds the reset for DELAY_TICKS reference ticks after the last request clears. A new request during the delay restarts it.
- R10: After power-on, `sys_rst_o` is low and the register reads 8'h02. The supply monitor is on, and the missing-clock and comparator enables are off.
- R11: A supply trip causes a reset (8'h02) only while the monitor is on. Writing bit 1 as 0 turns the monitor off.
- R12: Concurrent requests resolve by priority, highest first: supply, pin, missing clock, comparator, watchdog. During one reset, a higher-priority request replaces the recorded cause. A lower-priority request never replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running controller clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| ref_tick_i | input | 1 | One-cycle reference tick for stall and delay timing |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| vmon_trip_i | input | 1 | Supply monitor trip, active high, asynchronous |
| mon_clk_i | input | 1 | System clock under watch, sampled as data |
| cmp_out_i | input | 1 | Comparator output; 0 requests reset |
| wdt_expire_i | input | 1 | Watchdog expiry, one-cycle synchronous pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: bit 1 supply monitor, bit 2 missing-clock, bit 5 comparator enables |
| rd_data_o | output | 8 | Cause flags: bit 0 pin, 1 supply/power-on, 2 missing clock, 3 watchdog, 5 comparator |
| sys_rst_o | output | 1 | Internal system reset, active high |

## Verification
The assertions rely on four properties of the inputs. The reference tick is a single-cycle pulse. The watchdog expiry is already synchronous to the controller clock. Asynchronous requests last long enough to pass the synchronizer. Software writes only while out of reset. The stimulus respects all four. It drives inputs half a cycle away from the sampling edge and holds each pin level for at least five cycles. It pulses the tick every fourth cycle and issues writes only after the reset has released. Stalls of the monitored clock are made by stopping its toggling for a chosen number of cycles, both shorter and longer than the tick limit.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

   localparam int NUM_SRC = 5;
   localparam int CSR_W   = 8;

   localparam int BIT_PIN    = 0;
   localparam int BIT_SUPPLY = 1;
   localparam int BIT_MCD    = 2;
   localparam int BIT_WDT    = 3;
   localparam int BIT_CMP    = 5;

   // lower code means higher priority
   typedef enum logic [2:0] {
      SRC_SUPPLY = 3'd0,
      SRC_PIN    = 3'd1,
      SRC_MCD    = 3'd2,
      SRC_CMP    = 3'd3,
      SRC_WDT    = 3'd4
   } src_e;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HOLD  = 2'd1,
      ST_DELAY = 2'd2
   } seq_st_e;

   function automatic logic [CSR_W-1:0] flag_of(src_e s);
      logic [CSR_W-1:0] f;
      f = '0;
      case (s)
         SRC_SUPPLY: f[BIT_SUPPLY] = 1'b1;
         SRC_PIN:    f[BIT_PIN]    = 1'b1;
         SRC_MCD:    f[BIT_MCD]    = 1'b1;
         SRC_CMP:    f[BIT_CMP]    = 1'b1;
         SRC_WDT:    f[BIT_WDT]    = 1'b1;
         default:    f = '0;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             por_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rcc_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("rcc_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         stg_q <= {STAGES{RST_VAL}};
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rcc_clk_watch.sv
module rcc_clk_watch #(
   parameter int LIMIT = 8
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic tick_i,
   input  logic en_i,
   input  logic lvl_i,
   output logic timeout_o
);

   localparam int             CW    = $clog2(LIMIT + 1);
   localparam logic [CW-1:0]  LIM_V = CW'(LIMIT);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("rcc_clk_watch: LIMIT must be at least 2");
      end
   endgenerate

   logic          lvl_q;
   logic          edge_seen;
   logic [CW-1:0] cnt_q;

   assign edge_seen = lvl_i ^ lvl_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         lvl_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         lvl_q <= lvl_i;
         if (!en_i || edge_seen) begin
            cnt_q <= '0;
         end else if (tick_i && (cnt_q != LIM_V)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign timeout_o = (cnt_q == LIM_V);

   AST_WATCH_BOUND: assert property (@(posedge clk_i) disable iff (!por_n_i)
      cnt_q <= LIM_V);                                        // R3
   AST_WATCH_OFF: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !en_i |=> !timeout_o);                                  // R4

endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
   import rcc_pkg::*;
#(
   parameter int NSRC        = NUM_SRC,
   parameter int DELAY_TICKS = 16
) (
   input  logic            clk_i,
   input  logic            por_n_i,
   input  logic            tick_i,
   input  logic [NSRC-1:0] req_i,
   output logic            rst_o,
   output logic            release_o,
   output src_e            cause_o
);

   localparam int            DW   = $clog2(DELAY_TICKS + 1);
   localparam logic [DW-1:0] LAST = DW'(DELAY_TICKS - 1);

   generate
      if (DELAY_TICKS < 1) begin : g_bad_delay
         $error("rcc_seq: DELAY_TICKS must be at least 1");
      end
      if (NSRC != NUM_SRC) begin : g_bad_nsrc
         $error("rcc_seq: NSRC must match the source list");
      end
   endgenerate

   seq_st_e       st_q, st_n;
   src_e          cause_q, cause_n;
   logic [DW-1:0] dcnt_q, dcnt_n;
   logic          any_req;
   src_e          top_src;

   assign any_req = |req_i;

   // lowest set index wins
   always_comb begin
      top_src = SRC_WDT;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i]) top_src = src_e'(3'(i));
      end
   end

   always_comb begin
      st_n    = st_q;
      cause_n = cause_q;
      dcnt_n  = dcnt_q;
      case (st_q)
         ST_RUN: begin
            if (any_req) begin
               st_n    = ST_HOLD;
               cause_n = top_src;
               dcnt_n  = '0;
            end
         end
         default: begin
            if (any_req) begin
               st_n   = ST_HOLD;
               dcnt_n = '0;
               if (top_src < cause_q) cause_n = top_src;
            end else if (st_q == ST_HOLD) begin
               dcnt_n = '0;
               st_n   = (cause_q == SRC_SUPPLY) ? ST_RUN : ST_DELAY;
            end else if (tick_i) begin
               if (dcnt_q == LAST) st_n = ST_RUN;
               else                dcnt_n = dcnt_q + 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         st_q    <= ST_HOLD;
         cause_q <= SRC_SUPPLY;
         dcnt_q  <= '0;
      end else begin
         st_q    <= st_n;
         cause_q <= cause_n;
         dcnt_q  <= dcnt_n;
      end
   end

   assign rst_o     = (st_q != ST_RUN);
   assign release_o = (st_q != ST_RUN) && (st_n == ST_RUN);
   assign cause_o   = cause_q;

   AST_REQ_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!por_n_i)
      any_req |=> rst_o);                                      // R1
   AST_SUPPLY_NO_WAIT: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (st_q == ST_HOLD && !any_req && cause_q == SRC_SUPPLY) |=> (st_q == ST_RUN)); // R9
   AST_DELAY_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (st_q == ST_DELAY && !any_req && !tick_i) |=> (st_q == ST_DELAY)); // R9
   AST_CAUSE_NO_DEMOTE: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (st_q != ST_RUN && $past(st_q) != ST_RUN) |-> (cause_q <= $past(cause_q))); // R12

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
   import rcc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DELAY_TICKS = 16,
   parameter int MCD_TICKS   = 8
) (
   input  logic             clk_i,
   input  logic             por_n_i,
   input  logic             ref_tick_i,
   input  logic             ext_rst_n_i,
   input  logic             vmon_trip_i,
   input  logic             mon_clk_i,
   input  logic             cmp_out_i,
   input  logic             wdt_expire_i,
   input  logic             wr_en_i,
   input  logic [CSR_W-1:0] wr_data_i,
   output logic [CSR_W-1:0] rd_data_o,
   output logic             sys_rst_o
);

   localparam int           NA       = 4;
   localparam logic [NA-1:0] SYNC_RST = 4'b0101; // clk=0, cmp=1, vmon=0, pin=1

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rst_cause_ctrl: SYNC_STAGES must be at least 2");
      end
      if (CSR_W <= BIT_CMP) begin : g_bad_csr
         $error("rst_cause_ctrl: register too narrow for the flag layout");
      end
   endgenerate

   logic [NA-1:0]      async_s;
   logic               ext_n_s, vmon_s, cmp_s, mclk_s;
   logic               mon_en_q, mcd_en_q, cmp_en_q, sw_pwr_req_q;
   logic [CSR_W-1:0]   flags_q;
   logic               mcd_timeout;
   logic [NUM_SRC-1:0] req;
   logic               seq_rst, seq_rel;
   src_e               seq_cause;
   logic               unused_wr;

   rcc_sync #(
      .WIDTH  (NA),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) i_sync (
      .clk_i  (clk_i),
      .por_n_i(por_n_i),
      .d_i    ({mon_clk_i, cmp_out_i, vmon_trip_i, ext_rst_n_i}),
      .q_o    (async_s)
   );

   assign ext_n_s = async_s[0];
   assign vmon_s  = async_s[1];
   assign cmp_s   = async_s[2];
   assign mclk_s  = async_s[3];

   rcc_clk_watch #(
      .LIMIT(MCD_TICKS)
   ) i_watch (
      .clk_i    (clk_i),
      .por_n_i  (por_n_i),
      .tick_i   (ref_tick_i),
      .en_i     (mcd_en_q),
      .lvl_i    (mclk_s),
      .timeout_o(mcd_timeout)
   );

   always_comb begin
      req                = '0;
      req[int'(SRC_SUPPLY)] = (mon_en_q & vmon_s) | sw_pwr_req_q;
      req[int'(SRC_PIN)]    = ~ext_n_s;
      req[int'(SRC_MCD)]    = mcd_en_q & mcd_timeout;
      req[int'(SRC_CMP)]    = cmp_en_q & ~cmp_s;
      req[int'(SRC_WDT)]    = wdt_expire_i;
   end

   rcc_seq #(
      .NSRC       (NUM_SRC),
      .DELAY_TICKS(DELAY_TICKS)
   ) i_seq (
      .clk_i    (clk_i),
      .por_n_i  (por_n_i),
      .tick_i   (ref_tick_i),
      .req_i    (req),
      .rst_o    (seq_rst),
      .release_o(seq_rel),
      .cause_o  (seq_cause)
   );

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         mon_en_q     <= 1'b1;
         mcd_en_q     <= 1'b0;
         cmp_en_q     <= 1'b0;
         sw_pwr_req_q <= 1'b0;
         flags_q      <= '0;
      end else if (seq_rel) begin
         flags_q      <= flag_of(seq_cause);
         mcd_en_q     <= 1'b0;
         cmp_en_q     <= 1'b0;
         sw_pwr_req_q <= 1'b0;
      end else if (wr_en_i && !seq_rst) begin
         mon_en_q     <= wr_data_i[BIT_SUPPLY];
         mcd_en_q     <= wr_data_i[BIT_MCD];
         cmp_en_q     <= wr_data_i[BIT_CMP];
         sw_pwr_req_q <= wr_data_i[BIT_SUPPLY] & ~mon_en_q;
      end else begin
         sw_pwr_req_q <= 1'b0;
      end
   end

   assign unused_wr = ^{wr_data_i[CSR_W-1:BIT_CMP+1], wr_data_i[BIT_CMP-1:BIT_WDT],
                        wr_data_i[BIT_PIN]};

   assign rd_data_o = flags_q;
   assign sys_rst_o = seq_rst;

   AST_FLAGS_ONEHOT: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $onehot0(flags_q));                                      // R2
   AST_FLAGS_HELD_RUN: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!sys_rst_o && $past(!sys_rst_o)) |-> $stable(flags_q)); // R2
   AST_NO_SELF_RST_WHEN_ON: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (wr_en_i && !sys_rst_o && wr_data_i[BIT_SUPPLY] && mon_en_q) |=> !sw_pwr_req_q); // R8
   AST_SWREQ_FORCES: assert property (@(posedge clk_i) disable iff (!por_n_i)
      sw_pwr_req_q |=> sys_rst_o);                             // R7

endmodule

// File: tb/test_rst_cause_ctrl.sv
module test_rst_cause_ctrl;

   localparam int DLY = 16;
   localparam int MCD = 8;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       tick = 1'b0;
   logic       ext_n = 1'b1;
   logic       vmon = 1'b0;
   logic       mclk = 1'b0;
   logic       cmp = 1'b1;
   logic       wdt = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       sys_rst;

   int n_chk  = 0;
   int n_fail = 0;
   int rise_cnt = 0;
   int rst_len  = 0;
   logic rst_prev = 1'b1;
   logic mclk_run = 1'b1;

   rst_cause_ctrl #(
      .SYNC_STAGES(2),
      .DELAY_TICKS(DLY),
      .MCD_TICKS  (MCD)
   ) i_rst_cause_ctrl (
      .clk_i       (clk),
      .por_n_i     (por_n),
      .ref_tick_i  (tick),
      .ext_rst_n_i (ext_n),
      .vmon_trip_i (vmon),
      .mon_clk_i   (mclk),
      .cmp_out_i   (cmp),
      .wdt_expire_i(wdt),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .rd_data_o   (rd_data),
      .sys_rst_o   (sys_rst)
   );

   always #10 clk = ~clk;

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (mclk_run) mclk = ~mclk;
      if (por_n) begin
         if (sys_rst && !rst_prev) begin
            rise_cnt = rise_cnt + 1;
            rst_len  = 0;
         end
         if (sys_rst) rst_len = rst_len + 1;
      end
      rst_prev = sys_rst;
   end

   task automatic check_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_in(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wait_release();
      for (int i = 0; i < 400; i++) begin
         if (!sys_rst) break;
         wait_cyc(1);
      end
      wait_cyc(2);
   endtask

   task automatic reg_write(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      #1;
   endtask

   task automatic wdt_pulse();
      @(negedge clk);
      wdt = 1'b1;
      @(negedge clk);
      wdt = 1'b0;
      #1;
   endtask

   task automatic t_power_on();
      check_eq("R10 reset out low", sys_rst, 0);
      check_eq("R10 flags after power-on", rd_data, 8'h02);
   endtask

   task automatic t_pin();
      ext_n = 1'b0;
      wait_cyc(10);
      check_eq("R1 reset held by pin", sys_rst, 1);
      ext_n = 1'b1;
      wait_release();
      check_eq("R1 pin flag", rd_data, 8'h01);
      check_in("R9 pin reset length", rst_len, 10 + DLY*4 - 4, 10 + DLY*4 + 12);
   endtask

   task automatic t_wdt();
      wdt_pulse();
      wait_release();
      check_eq("R6 watchdog flag only", rd_data, 8'h08);
      check_in("R9 watchdog delay length", rst_len, DLY*4 - 4, DLY*4 + 6);
   endtask

   task automatic t_mcd();
      int r0;
      r0 = rise_cnt;
      mclk_run = 1'b0;
      wait_cyc(MCD*4 + 30);
      mclk_run = 1'b1;
      wait_cyc(10);
      check_eq("R4 stall ignored while disabled", rise_cnt, r0);
      reg_write(8'h06);
      mclk_run = 1'b0;
      wait_cyc(14);
      mclk_run = 1'b1;
      wait_cyc(10);
      check_eq("R3 short stall no reset", rise_cnt, r0);
      mclk_run = 1'b0;
      wait_cyc(MCD*4 + 20);
      check_eq("R3 long stall holds reset", sys_rst, 1);
      mclk_run = 1'b1;
      wait_release();
      check_eq("R3 missing clock flag", rd_data, 8'h04);
      r0 = rise_cnt;
      mclk_run = 1'b0;
      wait_cyc(MCD*4 + 30);
      mclk_run = 1'b1;
      wait_cyc(10);
      check_eq("R4 enable cleared by reset", rise_cnt, r0);
   endtask

   task automatic t_cmp();
      int r0;
      r0 = rise_cnt;
      cmp = 1'b0;
      wait_cyc(20);
      cmp = 1'b1;
      wait_cyc(5);
      check_eq("R5 comparator ignored while disabled", rise_cnt, r0);
      reg_write(8'h22);
      cmp = 1'b0;
      wait_cyc(20);
      check_eq("R5 comparator holds reset", sys_rst, 1);
      cmp = 1'b1;
      wait_release();
      check_eq("R5 comparator flag", rd_data, 8'h20);
      r0 = rise_cnt;
      cmp = 1'b0;
      wait_cyc(20);
      cmp = 1'b1;
      wait_cyc(5);
      check_eq("R5 comparator enable cleared by reset", rise_cnt, r0);
   endtask

   task automatic t_supply();
      int r0;
      vmon = 1'b1;
      wait_cyc(6);
      vmon = 1'b0;
      wait_release();
      check_eq("R11 supply trip flag", rd_data, 8'h02);
      check_in("R9 supply reset no delay", rst_len, 1, 12);
      reg_write(8'h00);
      r0 = rise_cnt;
      vmon = 1'b1;
      wait_cyc(20);
      vmon = 1'b0;
      wait_cyc(5);
      check_eq("R11 trip ignored while monitor off", rise_cnt, r0);
      wdt_pulse();
      wait_release();
      r0 = rise_cnt;
      reg_write(8'h02);
      wait_cyc(6);
      check_eq("R7 enabling monitor resets", rise_cnt, r0 + 1);
      check_eq("R7 supply flag", rd_data, 8'h02);
      check_in("R9 forced reset short", rst_len, 1, 3);
      r0 = rise_cnt;
      reg_write(8'h02);
      wait_cyc(10);
      check_eq("R8 rewrite while on no reset", rise_cnt, r0);
      vmon = 1'b1;
      wait_cyc(6);
      vmon = 1'b0;
      wait_cyc(5);
      check_eq("R7 monitor still on after reset", rise_cnt, r0 + 1);
   endtask

   task automatic t_priority();
      ext_n = 1'b0;
      wait_cyc(5);
      wdt_pulse();
      wait_cyc(5);
      ext_n = 1'b1;
      wait_release();
      check_eq("R12 lower source does not replace pin", rd_data, 8'h01);
      reg_write(8'h22);
      @(negedge clk);
      cmp = 1'b0;
      wdt = 1'b1;
      @(negedge clk);
      wdt = 1'b0;
      wait_cyc(5);
      cmp = 1'b1;
      wait_release();
      check_eq("R12 comparator beats watchdog", rd_data, 8'h20);
      ext_n = 1'b0;
      vmon = 1'b1;
      wait_cyc(8);
      ext_n = 1'b1;
      vmon = 1'b0;
      wait_release();
      check_eq("R12 supply beats pin", rd_data, 8'h02);
      ext_n = 1'b0;
      wait_cyc(5);
      ext_n = 1'b1;
      wait_cyc(20);
      check_eq("R9 still in delay", sys_rst, 1);
      wdt_pulse();
      wait_release();
      check_eq("R2 pin flag kept over watchdog", rd_data, 8'h01);
      check_in("R9 delay restarted", rst_len, 5 + 20 + DLY*4 - 4, 5 + 20 + DLY*4 + 16);
   endtask

   initial begin
      wait_cyc(5);
      por_n = 1'b1;
      wait_cyc(10);
      t_power_on();
      t_pin();
      t_wdt();
      t_mcd();
      t_cmp();
      t_supply();
      t_priority();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule